// File: doc/BRIEF.md
# Adaptive Latency-Insensitive Core Wrapper

This block wraps an unmodified synchronous core so that the core keeps working when the wires between it and its neighbours are cut by any number of pipeline registers. Every input channel and every output channel carries data, a valid flag and a backward stop flag. The wrapper issues a clock enable to the core (a "fire") only in a cycle where every input the core needs holds an item and no output is being held back by its receiver. In every other cycle the core state is frozen, and each output sends a void token. If a receiver is stopping, the outputs keep their current values instead.

Each cycle the core also supplies a skip mask, which names the inputs it will not read in its next step. In adaptive mode a skipped input cannot block a fire. Any item that sits on a skipped input at a fire is consumed and thrown away. A channel that is idle for long stretches, such as a read-return path during a burst of writes, then stops capping the rate of the loop it belongs to. A parameter selects the strict rule instead, under which every input is needed at every fire, so the two rules can be compared side by side.

Each input has a single holding register that acts as a bypass queue. An item that arrives in a cycle without a fire is kept there, and the input raises its stop flag until a fire takes the item.

Top module: `adaptive_shell`

## Requirements
- R1: After reset has been released and synchronised (two clock edges), every `out_valid` bit and every `in_stop` bit is 0. While the internal reset is still held, `in_stop` is all ones.
- R2: `core_en` is 1 in any cycle where every needed input has an item and all `out_stop` bits are 0. In the next cycle every `out_valid` bit is 1, and output lane k (bits k*DATA_W upward) equals lane k of `core_out_data` from the firing cycle.
- R3: After a cycle with no fire and no `out_stop` bit set, every `out_valid` bit is 0 (a void token).
- R4: While any `out_stop` bit is 1, `core_en` is 0, and in the next cycle `out_valid` and `out_data` are unchanged on all lanes.
- R5: An item offered on input i (`in_valid[i]`=1 with `in_stop[i]`=0) in a cycle without a fire is kept. From the next cycle `in_stop[i]` is 1 until a fire, and `in_data` on that lane is ignored while `in_stop[i]` is 1.
- R6: Lane i of `core_in_data` shows the held item of input i if there is one, and otherwise the live `in_data` lane. `core_in_avail[i]` is 1 when either source holds an item.
- R7: A fire consumes every item present on every input, so in the cycle after a fire every `in_stop` bit is 0.
- R8: With ADAPTIVE=1, an input whose `core_skip` bit is 1 does not block a fire. An item present on it at that fire is discarded and never appears on `core_in_data` afterwards.
- R9: With ADAPTIVE=0, `core_skip` has no effect, and a fire needs an item on every input.
- R10: In a closed loop with a memory-like core, reads return the data last written to their address, and the adaptive rule fires at least 1.5 times as often as the strict rule. The strict rule fires about once per three cycles in a loop holding three registers and one token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | NUM_IN*DATA_W | Input channel data, lane i at bits i*DATA_W |
| in_valid | input | NUM_IN | Input channel carries an item |
| in_stop | output | NUM_IN | Tells the sender of input i to hold its item |
| out_data | output | NUM_OUT*DATA_W | Output channel data |
| out_valid | output | NUM_OUT | Output channel carries an item (0 = void) |
| out_stop | input | NUM_OUT | Receiver of output k cannot accept |
| core_en | output | 1 | Clock enable (fire) for the wrapped core |
| core_in_data | output | NUM_IN*DATA_W | Items presented to the core |
| core_in_avail | output | NUM_IN | Input i has an item this cycle |
| core_skip | input | NUM_IN | Core will not read input i in its next step |
| core_out_data | input | NUM_OUT*DATA_W | Core results, captured on a fire |

## Verification
A wrongly set holding flag shows up in the cycle after the fault as a stop flag that is stuck high or missing on that input. It also leads to either a fire that repeats a stale item on `core_in_data` or an item that never arrives, and in a loop that lost item stalls the core for good. A wrong fire decision shows on `out_valid` one cycle later, as a void where data was due or as data that breaks the hold under backpressure. In the closed loop, a discarded item that is wrongly kept breaks the read data within one round trip. A fire rule that is too strict shows up only as a lower fire count over the run.

// File: rtl/shell_pkg.sv
package shell_pkg;

  typedef enum logic {
    RULE_STRICT   = 1'b0,
    RULE_ADAPTIVE = 1'b1
  } fire_rule_e;

  function automatic fire_rule_e rule_from_param(input int adaptive);
    return (adaptive != 0) ? RULE_ADAPTIVE : RULE_STRICT;
  endfunction

endpackage

// File: rtl/shell_rst_sync.sv
module shell_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/shell_in_slot.sv
module shell_in_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_valid,
  output logic              up_stop,
  input  logic              take,
  output logic [DATA_W-1:0] head_data,
  output logic              head_avail
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;

  // next state: a held item blocks the sender; an untaken offer is kept
  always_comb begin
    full_d  = full_q;
    data_en = 1'b0;
    if (full_q) begin
      if (take) full_d = 1'b0;
    end else if (up_valid && !take && run) begin
      full_d  = 1'b1;
      data_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= up_data;
  end

  assign up_stop    = full_q | ~run;
  assign head_avail = full_q | (up_valid & run);
  assign head_data  = full_q ? data_q : up_data;
endmodule

// File: rtl/shell_fire_ctl.sv
module shell_fire_ctl
  import shell_pkg::*;
#(
  parameter int NUM_IN   = 2,
  parameter int NUM_OUT  = 2,
  parameter int ADAPTIVE = 1
) (
  input  logic               run,
  input  logic [NUM_IN-1:0]  avail,
  input  logic [NUM_IN-1:0]  skip,
  input  logic [NUM_OUT-1:0] out_stop,
  output logic               fire,
  output logic [NUM_IN-1:0]  take
);
  localparam fire_rule_e RULE = rule_from_param(ADAPTIVE);

  logic [NUM_IN-1:0] needed;
  logic              inputs_ready;

  generate
    if (RULE == RULE_ADAPTIVE) begin : g_adaptive
      assign needed = ~skip;
    end else begin : g_strict
      logic [NUM_IN-1:0] unused_skip;
      assign unused_skip = skip;
      assign needed      = {NUM_IN{1'b1}};
    end
  endgenerate

  always_comb begin
    inputs_ready = &(avail | ~needed);
    fire         = run & inputs_ready & ~(|out_stop);
    // every present item leaves at a fire: needed ones to the core, skipped ones dropped
    take         = {NUM_IN{fire}} & avail;
  end
endmodule

// File: rtl/shell_out_reg.sv
module shell_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              hold,
  input  logic [DATA_W-1:0] core_data,
  output logic [DATA_W-1:0] data,
  output logic              valid
);
  logic valid_q, valid_d;
  logic data_en;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (!hold) valid_d = fire;
    data_en = fire & ~hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= core_data;
  end

  assign valid = valid_q;
  assign data  = data_q;
endmodule

// File: rtl/adaptive_shell.sv
module adaptive_shell #(
  parameter int NUM_IN   = 2,
  parameter int NUM_OUT  = 2,
  parameter int DATA_W   = 8,
  parameter int ADAPTIVE = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_IN*DATA_W-1:0]    in_data,
  input  logic [NUM_IN-1:0]           in_valid,
  output logic [NUM_IN-1:0]           in_stop,
  output logic [NUM_OUT*DATA_W-1:0]   out_data,
  output logic [NUM_OUT-1:0]          out_valid,
  input  logic [NUM_OUT-1:0]          out_stop,
  output logic                        core_en,
  output logic [NUM_IN*DATA_W-1:0]    core_in_data,
  output logic [NUM_IN-1:0]           core_in_avail,
  input  logic [NUM_IN-1:0]           core_skip,
  input  logic [NUM_OUT*DATA_W-1:0]   core_out_data
);
  logic              rst_q_n;
  logic [NUM_IN-1:0] avail;
  logic [NUM_IN-1:0] take;
  logic              fire;
  logic              out_hold;

  shell_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  generate
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
      shell_in_slot #(.DATA_W(DATA_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_q_n),
        .run        (rst_q_n),
        .up_data    (in_data[gi*DATA_W +: DATA_W]),
        .up_valid   (in_valid[gi]),
        .up_stop    (in_stop[gi]),
        .take       (take[gi]),
        .head_data  (core_in_data[gi*DATA_W +: DATA_W]),
        .head_avail (avail[gi])
      );
    end
  endgenerate

  shell_fire_ctl #(
    .NUM_IN   (NUM_IN),
    .NUM_OUT  (NUM_OUT),
    .ADAPTIVE (ADAPTIVE)
  ) u_fire (
    .run      (rst_q_n),
    .avail    (avail),
    .skip     (core_skip),
    .out_stop (out_stop),
    .fire     (fire),
    .take     (take)
  );

  assign out_hold = |out_stop;

  generate
    for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
      shell_out_reg #(.DATA_W(DATA_W)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_q_n),
        .fire      (fire),
        .hold      (out_hold),
        .core_data (core_out_data[go*DATA_W +: DATA_W]),
        .data      (out_data[go*DATA_W +: DATA_W]),
        .valid     (out_valid[go])
      );
    end
  endgenerate

  assign core_en       = fire;
  assign core_in_avail = avail;
endmodule

// File: rtl/adaptive_shell_chk.sv
module adaptive_shell_chk #(
  parameter int NUM_IN   = 2,
  parameter int NUM_OUT  = 2,
  parameter int DATA_W   = 8,
  parameter int ADAPTIVE = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_IN-1:0]         in_valid,
  input logic [NUM_IN-1:0]         in_stop,
  input logic [NUM_IN-1:0]         core_in_avail,
  input logic [NUM_IN-1:0]         core_skip,
  input logic [NUM_OUT-1:0]        out_valid,
  input logic [NUM_OUT-1:0]        out_stop,
  input logic [NUM_OUT*DATA_W-1:0] out_data,
  input logic                      core_en
);
  assert_no_fire_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_stop) |-> !core_en);

  assert_hold_under_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_stop) |=> ($stable(out_valid) && $stable(out_data)));

  assert_fire_fills_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |=> (&out_valid));

  assert_void_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_en && !(|out_stop)) |=> (out_valid == '0));

  assert_fire_drains_inputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |=> (in_stop == '0));

  generate
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in_chk
      assert_capture_raises_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[gi] && !in_stop[gi] && !core_en) |=> in_stop[gi]);
      assert_held_until_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop[gi] && !core_en) |=> in_stop[gi]);
    end
    if (ADAPTIVE != 0) begin : g_rule_ad
      assert_needed_inputs_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> ((core_in_avail | core_skip) == {NUM_IN{1'b1}}));
    end else begin : g_rule_st
      assert_all_inputs_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> (&core_in_avail));
    end
  endgenerate
endmodule

bind adaptive_shell adaptive_shell_chk #(
  .NUM_IN   (NUM_IN),
  .NUM_OUT  (NUM_OUT),
  .DATA_W   (DATA_W),
  .ADAPTIVE (ADAPTIVE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .in_valid      (in_valid),
  .in_stop       (in_stop),
  .core_in_avail (core_in_avail),
  .core_skip     (core_skip),
  .out_valid     (out_valid),
  .out_stop      (out_stop),
  .out_data      (out_data),
  .core_en       (core_en)
);

// File: tb/adaptive_shell_rig.sv
module tb_relay #(
  parameter int DW         = 8,
  parameter int INIT_VALID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] up_data,
  input  logic          up_valid,
  output logic          up_stop,
  output logic [DW-1:0] dn_data,
  output logic          dn_valid,
  input  logic          dn_stop
);
  logic          mv, av;
  logic [DW-1:0] md, ad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv <= (INIT_VALID != 0);
      md <= '0;
      av <= 1'b0;
      ad <= '0;
    end else if (!dn_stop) begin
      if (av) begin
        mv <= 1'b1;
        md <= ad;
        av <= 1'b0;
      end else begin
        mv <= up_valid;
        md <= up_data;
      end
    end else if (!av && up_valid) begin
      if (mv) begin
        av <= 1'b1;
        ad <= up_data;
      end else begin
        mv <= 1'b1;
        md <= up_data;
      end
    end
  end

  assign up_stop  = av;
  assign dn_data  = md;
  assign dn_valid = mv;
endmodule

module shell_loop_rig #(
  parameter int ADAPTIVE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] fires,
  output logic [31:0] reads_ok,
  output logic [31:0] reads_bad
);
  logic [7:0]  seq;
  logic [15:0] sh_in_data;
  logic [1:0]  sh_in_valid, sh_in_stop;
  logic [7:0]  sh_out_data;
  logic        sh_out_valid, sh_out_stop;
  logic        core_en;
  logic [15:0] core_in_data;
  logic [1:0]  core_in_avail, core_skip;
  logic [7:0]  core_out_data;
  logic [7:0]  a_data, ret_data, b_data;
  logic        a_valid, ret_valid, b_valid, b_up_stop, is_rd;
  logic [7:0]  mem [4];
  logic        prev_read;
  logic [7:0]  prev_seq;

  // command source: sequence numbers, held while stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq <= 8'd0;
    else if (!sh_in_stop[0]) seq <= seq + 8'd1;
  end

  assign sh_in_data  = {b_data, seq};
  assign sh_in_valid = {b_valid, 1'b1};

  adaptive_shell #(.NUM_IN(2), .NUM_OUT(1), .DATA_W(8), .ADAPTIVE(ADAPTIVE)) u_shell (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_data       (sh_in_data),
    .in_valid      (sh_in_valid),
    .in_stop       (sh_in_stop),
    .out_data      (sh_out_data),
    .out_valid     (sh_out_valid),
    .out_stop      (sh_out_stop),
    .core_en       (core_en),
    .core_in_data  (core_in_data),
    .core_in_avail (core_in_avail),
    .core_skip     (core_skip),
    .core_out_data (core_out_data)
  );

  tb_relay #(.DW(8), .INIT_VALID(0)) u_rs_a (
    .clk (clk), .rst_n (rst_n),
    .up_data (sh_out_data), .up_valid (sh_out_valid), .up_stop (sh_out_stop),
    .dn_data (a_data), .dn_valid (a_valid), .dn_stop (b_up_stop)
  );

  // memory: command low bits 11 = read, bits 3:2 = address, writes store the command
  assign is_rd     = (a_data[1:0] == 2'b11);
  assign ret_valid = a_valid && ((ADAPTIVE == 0) || is_rd);
  assign ret_data  = is_rd ? mem[a_data[3:2]] : 8'hAC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) mem[k] <= 8'd0;
    end else if (a_valid && !b_up_stop && !is_rd) begin
      mem[a_data[3:2]] <= a_data;
    end
  end

  tb_relay #(.DW(8), .INIT_VALID((ADAPTIVE == 0) ? 1 : 0)) u_rs_b (
    .clk (clk), .rst_n (rst_n),
    .up_data (ret_data), .up_valid (ret_valid), .up_stop (b_up_stop),
    .dn_data (b_data), .dn_valid (b_valid), .dn_stop (sh_in_stop[1])
  );

  // core: forwards the command, needs the return channel only after a read
  assign core_out_data = core_in_data[7:0];
  assign core_skip     = {~prev_read, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_read <= 1'b0;
      prev_seq  <= 8'd0;
      fires     <= 32'd0;
      reads_ok  <= 32'd0;
      reads_bad <= 32'd0;
    end else if (core_en) begin
      fires     <= fires + 32'd1;
      prev_read <= (core_in_data[1:0] == 2'b11);
      prev_seq  <= core_in_data[7:0];
      if (prev_read) begin
        if (core_in_data[15:8] == prev_seq - 8'd1) reads_ok  <= reads_ok + 32'd1;
        else                                       reads_bad <= reads_bad + 32'd1;
      end
    end
  end
endmodule

// File: tb/adaptive_shell_bench.sv
module adaptive_shell_bench;
  logic        clk;
  logic        rst_n;
  logic        rig_rst_n;
  logic [15:0] in_data;
  logic [1:0]  in_valid;
  logic [1:0]  out_stop;
  logic [1:0]  core_skip;
  logic [15:0] core_out_data;

  logic [1:0]  in_stop, out_valid, core_in_avail;
  logic [15:0] out_data, core_in_data;
  logic        core_en;
  logic [1:0]  st_in_stop, st_out_valid, st_core_in_avail;
  logic [15:0] st_out_data, st_core_in_data;
  logic        st_core_en;

  logic [31:0] ad_fires, ad_ok, ad_bad, st_fires, st_ok, st_bad;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  adaptive_shell #(.NUM_IN(2), .NUM_OUT(2), .DATA_W(8), .ADAPTIVE(1)) u_adaptive_shell (
    .clk (clk), .rst_n (rst_n),
    .in_data (in_data), .in_valid (in_valid), .in_stop (in_stop),
    .out_data (out_data), .out_valid (out_valid), .out_stop (out_stop),
    .core_en (core_en), .core_in_data (core_in_data), .core_in_avail (core_in_avail),
    .core_skip (core_skip), .core_out_data (core_out_data)
  );

  adaptive_shell #(.NUM_IN(2), .NUM_OUT(2), .DATA_W(8), .ADAPTIVE(0)) u_strict_shell (
    .clk (clk), .rst_n (rst_n),
    .in_data (in_data), .in_valid (in_valid), .in_stop (st_in_stop),
    .out_data (st_out_data), .out_valid (st_out_valid), .out_stop (out_stop),
    .core_en (st_core_en), .core_in_data (st_core_in_data), .core_in_avail (st_core_in_avail),
    .core_skip (core_skip), .core_out_data (core_out_data)
  );

  shell_loop_rig #(.ADAPTIVE(1)) u_loop_adaptive (
    .clk (clk), .rst_n (rig_rst_n), .fires (ad_fires), .reads_ok (ad_ok), .reads_bad (ad_bad)
  );
  shell_loop_rig #(.ADAPTIVE(0)) u_loop_strict (
    .clk (clk), .rst_n (rig_rst_n), .fires (st_fires), .reads_ok (st_ok), .reads_bad (st_bad)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] v, input logic [15:0] d, input logic [1:0] sk,
                       input logic [1:0] st, input logic [15:0] cod);
    @(negedge clk);
    in_valid = v; in_data = d; core_skip = sk; out_stop = st; core_out_data = cod;
    #5;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    check("R1 in_stop high during reset", {30'd0, in_stop}, 32'h3);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 out_valid after reset", {30'd0, out_valid}, 32'h0);
    check("R1 in_stop after reset", {30'd0, in_stop}, 32'h0);
  endtask

  task automatic t_fire();
    drive(2'b11, 16'h2211, 2'b00, 2'b00, 16'hB2A1);
    check("R2 fire with both inputs", {31'd0, core_en}, 32'h1);
    check("R6 live data to core", {16'd0, core_in_data}, 32'h2211);
    after_edge();
    check("R2 out_valid after fire", {30'd0, out_valid}, 32'h3);
    check("R2 out_data after fire", {16'd0, out_data}, 32'hB2A1);
    check("R7 stops clear after fire", {30'd0, in_stop}, 32'h0);
    drive(2'b00, 16'h0000, 2'b00, 2'b00, 16'hB2A1);
    check("R3 no fire without items", {31'd0, core_en}, 32'h0);
    after_edge();
    check("R3 void outputs", {30'd0, out_valid}, 32'h0);
  endtask

  task automatic t_slot();
    drive(2'b01, 16'h0033, 2'b00, 2'b00, 16'hC4C3);
    check("R5 no fire with one input", {31'd0, core_en}, 32'h0);
    after_edge();
    check("R5 stop raised on capture", {30'd0, in_stop}, 32'h1);
    drive(2'b11, 16'h5544, 2'b00, 2'b00, 16'hC4C3);
    check("R5 fire with held item", {31'd0, core_en}, 32'h1);
    check("R5 held item shown, live lane0 ignored", {16'd0, core_in_data}, 32'h5533);
    after_edge();
    check("R7 held item consumed", {30'd0, in_stop}, 32'h0);
  endtask

  task automatic t_stop();
    drive(2'b11, 16'h0102, 2'b00, 2'b00, 16'hC2C1);
    after_edge();
    check("R2 load before stop", {16'd0, out_data}, 32'hC2C1);
    drive(2'b11, 16'h5B5A, 2'b00, 2'b10, 16'hD2D1);
    check("R4 no fire under stop", {31'd0, core_en}, 32'h0);
    after_edge();
    check("R4 out_valid held", {30'd0, out_valid}, 32'h3);
    check("R4 out_data held", {16'd0, out_data}, 32'hC2C1);
    check("R5 both captured under stop", {30'd0, in_stop}, 32'h3);
    drive(2'b00, 16'h0000, 2'b00, 2'b00, 16'hD2D1);
    check("R4 fire after stop released", {31'd0, core_en}, 32'h1);
    check("R6 held items to core", {16'd0, core_in_data}, 32'h5B5A);
    after_edge();
    check("R2 new result after release", {16'd0, out_data}, 32'hD2D1);
  endtask

  task automatic t_skip();
    drive(2'b01, 16'h0066, 2'b10, 2'b00, 16'hE2E1);
    check("R8 skipped input does not block", {31'd0, core_en}, 32'h1);
    check("R9 strict rule ignores skip", {31'd0, st_core_en}, 32'h0);
    after_edge();
    check("R8 adaptive stops clear", {30'd0, in_stop}, 32'h0);
    check("R9 strict captured lane0", {30'd0, st_in_stop}, 32'h1);
    drive(2'b11, 16'h7788, 2'b10, 2'b00, 16'hE2E1);
    check("R8 fire with skipped item present", {31'd0, core_en}, 32'h1);
    check("R9 strict fires with all inputs", {31'd0, st_core_en}, 32'h1);
    after_edge();
    check("R8 skipped item not kept", {30'd0, in_stop}, 32'h0);
    drive(2'b11, 16'h99AA, 2'b00, 2'b00, 16'hE2E1);
    check("R8 discarded item never reappears", {16'd0, core_in_data}, 32'h99AA);
    after_edge();
    drive(2'b00, 16'h0000, 2'b00, 2'b00, 16'h0000);
    after_edge();
  endtask

  task automatic t_loop();
    rig_rst_n = 1'b1;
    repeat (600) @(posedge clk);
    #2;
    check("R10 adaptive read data", ad_bad, 32'd0);
    check("R10 strict read data", st_bad, 32'd0);
    check("R10 adaptive reads returned", {31'd0, (ad_ok > 32'd50)}, 32'h1);
    check("R10 strict reads returned", {31'd0, (st_ok > 32'd20)}, 32'h1);
    check("R10 strict rate one per three", {31'd0, (st_fires >= 32'd190 && st_fires <= 32'd201)}, 32'h1);
    check("R10 adaptive rate at least 1.5x strict", {31'd0, (ad_fires * 2 >= st_fires * 3)}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; rig_rst_n = 1'b0;
    in_valid = '0; in_data = '0; core_skip = '0; out_stop = '0; core_out_data = '0;
    repeat (2) @(posedge clk);
    #2;
    t_reset();
    t_fire();
    t_slot();
    t_stop();
    t_skip();
    t_loop();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule